// File: doc/BRIEF.md
# Remote-Scope Broadcast Coherence Sequencer

This block sits beside the shared last-level cache and serves atomic operations that a requester marks as remote-scoped. Each request names one address, the requesting private L1 and one of three kinds: an acquiring load, a releasing store or an acquire-release read-modify-write. The sequencer expands the request into a fixed program of steps. Each step is either a broadcast command to the private L1s (block local read-modify-writes, write back dirty lines, drop valid lines, lift the block) or a single access at the shared level.

A broadcast step raises a per-L1 valid line for every targeted cache and holds the command code steady. The step ends only when each targeted cache has returned an acknowledge pulse. The remote set is every L1 except the requester's own. After the last step the block returns one response beat carrying the value from the shared level. Only one such operation is handled at a time, and later requests wait with ready low.

Top module: `rsb_sequencer`

## Requirements
- R1: After reset, `req_ready` is 1 and `bc_valid`, `l2_valid` and `rsp_valid` are all 0.
- R2: An acquire (kind 0) performs a shared-level load (l2_op 0) at the request address, then a flush broadcast (bc_op 1) to the remote set, then an invalidate (bc_op 2) aimed only at the requester's L1, then responds with the loaded word.
- R3: A release (kind 1) runs, in order: lock (bc_op 0), flush, invalidate, shared-level store (l2_op 1), a second invalidate, then unlock (bc_op 3). All broadcasts go to the remote set, and the response data is 0.
- R4: A read-modify-write (kind 2) runs, in order: lock, flush, invalidate, shared-level RMW (l2_op 2), flush, invalidate, unlock. All broadcasts go to the remote set, and the response carries the old value returned by the shared level.
- R5: The remote set has bit i set for every L1 index i other than the requester's, which is NUM_L1−1 bits.
- R6: Within a broadcast step, `bc_valid[i]` stays high until `bc_ack[i]` is seen. The next step starts only after every targeted bit has cleared.
- R7: An acknowledge on an L1 that has no pending command is ignored. It neither ends a step nor sets a pending bit.
- R8: Only one operation is in flight. `req_ready` is low from the cycle after acceptance through the response beat, and it is high again in the cycle after `rsp_valid`.
- R9: `bc_op` does not change while any `bc_valid` bit is high.
- R10: A shared-level request holds `l2_valid`, `l2_op`, `l2_addr` and `l2_wdata` steady until `l2_done`.
- R11: The response is a single-cycle `rsp_valid` beat with `rsp_src` equal to the requester index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Remote-scoped request present |
| req_ready | output | 1 | Sequencer can take a request |
| req_kind | input | 2 | 0 acquire, 1 release, 2 read-modify-write |
| req_src | input | SRC_W | Index of the requesting L1 |
| req_addr | input | ADDR_W | Target address |
| req_wdata | input | DATA_W | Store or RMW operand |
| bc_valid | output | NUM_L1 | Per-L1 command valid |
| bc_op | output | 2 | 0 lock, 1 flush, 2 invalidate, 3 unlock |
| bc_ack | input | NUM_L1 | Per-L1 acknowledge pulse |
| l2_valid | output | 1 | Shared-level access request |
| l2_op | output | 2 | 0 load, 1 store, 2 RMW |
| l2_addr | output | ADDR_W | Shared-level address |
| l2_wdata | output | DATA_W | Shared-level write operand |
| l2_done | input | 1 | Shared-level access complete |
| l2_rdata | input | DATA_W | Shared-level returned word |
| rsp_valid | output | 1 | Response beat |
| rsp_src | output | SRC_W | Requester of the response |
| rsp_data | output | DATA_W | Response word |

## Verification
The hardest case to reach from the ports is a broadcast step that stays open on one straggling cache while every other cache, the requester's own included, sends stray acknowledge pulses. The stimulus sets this up by keeping one L1 model silent at the start of a release. Once only that bit is still valid, it drives acknowledges on all the other lines for several cycles and checks that the lock step neither ends nor changes its command. It then lets the straggler answer. A second request is also held on the request port during a whole read-modify-write. Any early acceptance would show up as an unexpected extra step in the scoreboard.

// File: rtl/rsb_pkg.sv
package rsb_pkg;

    typedef enum logic [1:0] {
        KIND_ACQ = 2'd0,
        KIND_REL = 2'd1,
        KIND_RMW = 2'd2,
        KIND_RSV = 2'd3
    } kind_e;

    typedef enum logic [1:0] {
        BOP_LOCK   = 2'd0,
        BOP_FLUSH  = 2'd1,
        BOP_INV    = 2'd2,
        BOP_UNLOCK = 2'd3
    } bop_e;

    typedef enum logic [1:0] {
        L2OP_LOAD  = 2'd0,
        L2OP_STORE = 2'd1,
        L2OP_RMW   = 2'd2,
        L2OP_NONE  = 2'd3
    } l2op_e;

    typedef enum logic [2:0] {
        STEP_LOCK   = 3'd0,
        STEP_FLUSH  = 3'd1,
        STEP_INV    = 3'd2,
        STEP_UNLOCK = 3'd3,
        STEP_LINV   = 3'd4,
        STEP_L2     = 3'd5,
        STEP_END    = 3'd6
    } step_e;

    typedef enum logic [1:0] {
        FSM_IDLE = 2'd0,
        FSM_RUN  = 2'd1,
        FSM_RESP = 2'd2
    } fsm_e;

    localparam int STEP_IDX_W = 3;

endpackage

// File: rtl/rsb_step_program.sv
module rsb_step_program
    import rsb_pkg::*;
(
    input  kind_e                 kind,
    input  logic [STEP_IDX_W-1:0] idx,
    output step_e                 step,
    output bop_e                  bop,
    output logic                  is_bcast,
    output l2op_e                 l2op
);

    always_comb begin
        step = STEP_END;
        unique case (kind)
            KIND_ACQ: begin
                case (idx)
                    3'd0:    step = STEP_L2;
                    3'd1:    step = STEP_FLUSH;
                    3'd2:    step = STEP_LINV;
                    default: step = STEP_END;
                endcase
            end
            KIND_REL: begin
                case (idx)
                    3'd0:    step = STEP_LOCK;
                    3'd1:    step = STEP_FLUSH;
                    3'd2:    step = STEP_INV;
                    3'd3:    step = STEP_L2;
                    3'd4:    step = STEP_INV;
                    3'd5:    step = STEP_UNLOCK;
                    default: step = STEP_END;
                endcase
            end
            KIND_RMW: begin
                case (idx)
                    3'd0:    step = STEP_LOCK;
                    3'd1:    step = STEP_FLUSH;
                    3'd2:    step = STEP_INV;
                    3'd3:    step = STEP_L2;
                    3'd4:    step = STEP_FLUSH;
                    3'd5:    step = STEP_INV;
                    3'd6:    step = STEP_UNLOCK;
                    default: step = STEP_END;
                endcase
            end
            default: step = STEP_END;
        endcase
    end

    always_comb begin
        bop      = BOP_LOCK;
        is_bcast = 1'b0;
        case (step)
            STEP_LOCK:   begin bop = BOP_LOCK;   is_bcast = 1'b1; end
            STEP_FLUSH:  begin bop = BOP_FLUSH;  is_bcast = 1'b1; end
            STEP_INV:    begin bop = BOP_INV;    is_bcast = 1'b1; end
            STEP_LINV:   begin bop = BOP_INV;    is_bcast = 1'b1; end
            STEP_UNLOCK: begin bop = BOP_UNLOCK; is_bcast = 1'b1; end
            default:     begin bop = BOP_LOCK;   is_bcast = 1'b0; end
        endcase
    end

    always_comb begin
        case (kind)
            KIND_ACQ: l2op = L2OP_LOAD;
            KIND_REL: l2op = L2OP_STORE;
            KIND_RMW: l2op = L2OP_RMW;
            default:  l2op = L2OP_NONE;
        endcase
    end

endmodule

// File: rtl/rsb_ack_tracker.sv
module rsb_ack_tracker #(
    parameter int NUM_L1 = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [NUM_L1-1:0] load_mask,
    input  logic [NUM_L1-1:0] ack,
    output logic [NUM_L1-1:0] pending,
    output logic              all_clear
);

    logic [NUM_L1-1:0] pending_d, pending_q;

    always_comb begin
        pending_d = pending_q & ~ack;
        if (load) begin
            pending_d = load_mask;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending_q <= '0;
        end else begin
            pending_q <= pending_d;
        end
    end

    assign pending   = pending_q;
    assign all_clear = (pending_q == '0);

    // R7
    no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ((pending_q & ~$past(pending_q)) == '0));

    // R6
    hold_until_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && ((pending_q & ~ack) != '0)) |=>
            ((pending_q & $past(pending_q & ~ack)) == $past(pending_q & ~ack)));

endmodule

// File: rtl/rsb_sequencer.sv
module rsb_sequencer
    import rsb_pkg::*;
#(
    parameter int NUM_L1 = 8,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int SRC_W  = (NUM_L1 > 1) ? $clog2(NUM_L1) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_kind,
    input  logic [SRC_W-1:0]  req_src,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [NUM_L1-1:0] bc_valid,
    output logic [1:0]        bc_op,
    input  logic [NUM_L1-1:0] bc_ack,
    output logic              l2_valid,
    output logic [1:0]        l2_op,
    output logic [ADDR_W-1:0] l2_addr,
    output logic [DATA_W-1:0] l2_wdata,
    input  logic              l2_done,
    input  logic [DATA_W-1:0] l2_rdata,
    output logic              rsp_valid,
    output logic [SRC_W-1:0]  rsp_src,
    output logic [DATA_W-1:0] rsp_data
);

    localparam logic [NUM_L1-1:0] ALL_L1 = {NUM_L1{1'b1}};
    localparam int MAX_TARGETS = (NUM_L1 > 1) ? NUM_L1 - 1 : 1;

    typedef struct packed {
        fsm_e                  st;
        logic [STEP_IDX_W-1:0] idx;
        logic                  armed;
        kind_e                 kind;
        logic [SRC_W-1:0]      src;
        logic [ADDR_W-1:0]     addr;
        logic [DATA_W-1:0]     wdata;
        logic [DATA_W-1:0]     rdata;
    } seq_t;

    seq_t seq_d, seq_q;

    step_e             cur_step;
    bop_e              cur_bop;
    logic              cur_bcast;
    l2op_e             cur_l2op;
    logic              trk_load;
    logic [NUM_L1-1:0] trk_mask;
    logic [NUM_L1-1:0] trk_pending;
    logic              trk_clear;
    logic [NUM_L1-1:0] own_mask;
    logic [NUM_L1-1:0] remote_mask;

    rsb_step_program u_program (
        .kind     (seq_q.kind),
        .idx      (seq_q.idx),
        .step     (cur_step),
        .bop      (cur_bop),
        .is_bcast (cur_bcast),
        .l2op     (cur_l2op)
    );

    rsb_ack_tracker #(.NUM_L1(NUM_L1)) u_tracker (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (trk_load),
        .load_mask (trk_mask),
        .ack       (bc_ack),
        .pending   (trk_pending),
        .all_clear (trk_clear)
    );

    generate
        for (genvar g = 0; g < NUM_L1; g++) begin : g_masks
            assign own_mask[g]    = (seq_q.src == SRC_W'(g));
            assign remote_mask[g] = (seq_q.src != SRC_W'(g));
        end
    endgenerate

    always_comb begin
        seq_d     = seq_q;
        req_ready = 1'b0;
        trk_load  = 1'b0;
        trk_mask  = '0;
        l2_valid  = 1'b0;
        rsp_valid = 1'b0;
        unique case (seq_q.st)
            FSM_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    seq_d.st    = FSM_RUN;
                    seq_d.idx   = '0;
                    seq_d.armed = 1'b0;
                    seq_d.kind  = kind_e'(req_kind);
                    seq_d.src   = req_src;
                    seq_d.addr  = req_addr;
                    seq_d.wdata = req_wdata;
                    seq_d.rdata = '0;
                end
            end
            FSM_RUN: begin
                if (cur_step == STEP_END) begin
                    seq_d.st = FSM_RESP;
                end else if (cur_step == STEP_L2) begin
                    l2_valid = 1'b1;
                    if (l2_done) begin
                        seq_d.rdata = (seq_q.kind == KIND_REL) ? '0 : l2_rdata;
                        seq_d.idx   = seq_q.idx + 1'b1;
                    end
                end else if (cur_bcast) begin
                    if (!seq_q.armed) begin
                        trk_load    = 1'b1;
                        trk_mask    = (cur_step == STEP_LINV) ? own_mask
                                                              : (remote_mask & ALL_L1);
                        seq_d.armed = 1'b1;
                    end else if (trk_clear) begin
                        seq_d.armed = 1'b0;
                        seq_d.idx   = seq_q.idx + 1'b1;
                    end
                end
            end
            FSM_RESP: begin
                rsp_valid = 1'b1;
                seq_d.st  = FSM_IDLE;
            end
            default: begin
                seq_d.st = FSM_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '{st: FSM_IDLE, idx: '0, armed: 1'b0, kind: KIND_ACQ,
                       src: '0, addr: '0, wdata: '0, rdata: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign bc_valid = trk_pending;
    assign bc_op    = cur_bop;
    assign l2_op    = cur_l2op;
    assign l2_addr  = seq_q.addr;
    assign l2_wdata = seq_q.wdata;
    assign rsp_src  = seq_q.src;
    assign rsp_data = seq_q.rdata;

    // R9
    op_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|bc_valid) && $past(|bc_valid)) |-> $stable(bc_op));

    // R10
    l2_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (l2_valid && !l2_done) |=>
            (l2_valid && $stable(l2_addr) && $stable(l2_op) && $stable(l2_wdata)));

    // R8
    single_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R8
    ready_after_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> req_ready);

    // R11
    rsp_single_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R5
    target_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(bc_valid) <= MAX_TARGETS);

    // R2
    phase_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(l2_valid && (|bc_valid)));

endmodule

// File: tb/rsb_sequencer_bench.sv
module rsb_sequencer_bench;

    localparam int N  = 8;
    localparam int SW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_kind = '0;
    logic [SW-1:0] req_src = '0;
    logic [31:0]   req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic [N-1:0]  bc_valid;
    logic [1:0]    bc_op;
    logic [N-1:0]  bc_ack = '0;
    logic          l2_valid;
    logic [1:0]    l2_op;
    logic [31:0]   l2_addr;
    logic [31:0]   l2_wdata;
    logic          l2_done = 1'b0;
    logic [31:0]   l2_rdata = '0;
    logic          rsp_valid;
    logic [SW-1:0] rsp_src;
    logic [31:0]   rsp_data;

    always #10 clk = ~clk;

    rsb_sequencer #(.NUM_L1(N), .ADDR_W(32), .DATA_W(32), .SRC_W(SW)) u_rsb_sequencer (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
        .req_src(req_src), .req_addr(req_addr), .req_wdata(req_wdata),
        .bc_valid(bc_valid), .bc_op(bc_op), .bc_ack(bc_ack),
        .l2_valid(l2_valid), .l2_op(l2_op), .l2_addr(l2_addr), .l2_wdata(l2_wdata),
        .l2_done(l2_done), .l2_rdata(l2_rdata),
        .rsp_valid(rsp_valid), .rsp_src(rsp_src), .rsp_data(rsp_data)
    );

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;

    logic [47:0] expq[$];
    string       tagq[$];

    logic [31:0] l2_mem [16];
    logic [31:0] shadow [16];

    logic [N-1:0]  hold_mask = '0;
    logic [N-1:0]  spur_mask = '0;
    logic [15:0]   lfsr = 16'hACE1;
    logic [N-1:0]  prev_bcv = '0;
    logic [N-1:0]  prev_ack = '0;
    logic [1:0]    phase_op = '0;
    bit            phase_bad_drop = 0;
    bit            phase_bad_op = 0;
    logic          prev_l2v = 1'b0;
    logic [31:0]   l2_lat_addr = '0;
    bit            l2_bad = 0;
    int            l2_wait = 0;
    int            rsp_cnt = 0;

    task automatic check(input string tag, input logic [47:0] act, input logic [47:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [47:0] mk(input logic [1:0] cls, input logic [1:0] op,
                                       input logic [7:0] src, input logic [31:0] v);
        return {cls, op, 4'd0, src, v};
    endfunction

    // Scoreboard monitor, L1 models and shared-level model
    always @(negedge clk) begin
        if (rst_n) begin
            // broadcast phases
            if (bc_valid != '0 && prev_bcv == '0) begin
                phase_op = bc_op;
                phase_bad_drop = 0;
                phase_bad_op = 0;
                if (expq.size() == 0) begin
                    check("R8 unexpected broadcast", mk(2'd0, bc_op, 8'd0, 32'(bc_valid)), '1);
                end else begin
                    check(tagq.pop_front(), mk(2'd0, bc_op, 8'd0, 32'(bc_valid)), expq.pop_front());
                end
            end
            if ((prev_bcv & ~bc_valid & ~prev_ack) != '0) phase_bad_drop = 1;
            if (bc_valid != '0 && bc_op != phase_op) phase_bad_op = 1;
            if (bc_valid == '0 && prev_bcv != '0) begin
                check("R6 drop only after ack", 48'(phase_bad_drop), 48'd0);
                check("R9 op stable in phase", 48'(phase_bad_op), 48'd0);
            end
            // shared level
            if (l2_valid && !prev_l2v) begin
                l2_lat_addr = l2_addr;
                l2_bad = 0;
                if (expq.size() == 0) begin
                    check("R8 unexpected l2", mk(2'd1, l2_op, 8'd0, l2_addr), '1);
                end else begin
                    check(tagq.pop_front(), mk(2'd1, l2_op, 8'd0, l2_addr), expq.pop_front());
                end
            end
            if (l2_valid && l2_addr !== l2_lat_addr) l2_bad = 1;
            l2_done = 1'b0;
            if (l2_valid && !l2_done_seen()) begin
                l2_wait++;
                if (l2_wait >= 3) begin
                    l2_wait = 0;
                    l2_done = 1'b1;
                    l2_rdata = l2_mem[l2_addr[3:0]];
                    if (l2_op == 2'd1) l2_mem[l2_addr[3:0]] = l2_wdata;
                    if (l2_op == 2'd2) l2_mem[l2_addr[3:0]] = l2_mem[l2_addr[3:0]] + l2_wdata;
                    check("R10 l2 request steady", 48'(l2_bad), 48'd0);
                end
            end
            prev_l2v = l2_valid;
            // response
            if (rsp_valid) begin
                rsp_cnt++;
                if (expq.size() == 0) begin
                    check("R11 unexpected rsp", mk(2'd2, 2'd0, 8'(rsp_src), rsp_data), '1);
                end else begin
                    check(tagq.pop_front(), mk(2'd2, 2'd0, 8'(rsp_src), rsp_data), expq.pop_front());
                end
            end
            // L1 acknowledge models
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            bc_ack = (bc_valid & ~hold_mask & lfsr[N-1:0]) | spur_mask;
            prev_ack = bc_ack;
            prev_bcv = bc_valid;
        end
    end

    function automatic bit l2_done_seen();
        return l2_done;
    endfunction

    task automatic run_op(input int kind, input int src, input logic [31:0] addr,
                          input logic [31:0] wdata, input string tag, input bit press);
        logic [N-1:0] remote = ~(N'(1) << src);
        logic [N-1:0] own    = N'(1) << src;
        logic [31:0]  old    = shadow[addr[3:0]];
        int start_cnt = rsp_cnt;
        bit busy_bad = 0;
        string rtag = (kind == 0) ? "R5" : tag;
        case (kind)
            0: begin
                expq.push_back(mk(2'd1, 2'd0, 8'd0, addr));       tagq.push_back(tag);
                expq.push_back(mk(2'd0, 2'd1, 8'd0, 32'(remote))); tagq.push_back(rtag);
                expq.push_back(mk(2'd0, 2'd2, 8'd0, 32'(own)));    tagq.push_back(tag);
                expq.push_back(mk(2'd2, 2'd0, 8'(src), old));      tagq.push_back("R11");
            end
            1: begin
                expq.push_back(mk(2'd0, 2'd0, 8'd0, 32'(remote))); tagq.push_back(tag);
                expq.push_back(mk(2'd0, 2'd1, 8'd0, 32'(remote))); tagq.push_back(tag);
                expq.push_back(mk(2'd0, 2'd2, 8'd0, 32'(remote))); tagq.push_back(tag);
                expq.push_back(mk(2'd1, 2'd1, 8'd0, addr));        tagq.push_back(tag);
                expq.push_back(mk(2'd0, 2'd2, 8'd0, 32'(remote))); tagq.push_back(tag);
                expq.push_back(mk(2'd0, 2'd3, 8'd0, 32'(remote))); tagq.push_back(tag);
                expq.push_back(mk(2'd2, 2'd0, 8'(src), 32'd0));    tagq.push_back(tag);
                shadow[addr[3:0]] = wdata;
            end
            default: begin
                expq.push_back(mk(2'd0, 2'd0, 8'd0, 32'(remote))); tagq.push_back(tag);
                expq.push_back(mk(2'd0, 2'd1, 8'd0, 32'(remote))); tagq.push_back(tag);
                expq.push_back(mk(2'd0, 2'd2, 8'd0, 32'(remote))); tagq.push_back(tag);
                expq.push_back(mk(2'd1, 2'd2, 8'd0, addr));        tagq.push_back(tag);
                expq.push_back(mk(2'd0, 2'd1, 8'd0, 32'(remote))); tagq.push_back(tag);
                expq.push_back(mk(2'd0, 2'd2, 8'd0, 32'(remote))); tagq.push_back(tag);
                expq.push_back(mk(2'd0, 2'd3, 8'd0, 32'(remote))); tagq.push_back(tag);
                expq.push_back(mk(2'd2, 2'd0, 8'(src), old));      tagq.push_back(tag);
                shadow[addr[3:0]] = old + wdata;
            end
        endcase
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        #1;
        req_valid = 1'b1; req_kind = 2'(kind); req_src = SW'(src);
        req_addr = addr; req_wdata = wdata;
        @(negedge clk);
        #1;
        if (press) begin
            req_kind = 2'd1; req_src = SW'((src + 1) % N); req_addr = 32'h5; req_wdata = 32'hDEAD;
        end else begin
            req_valid = 1'b0;
        end
        while (rsp_cnt == start_cnt) begin
            if (req_ready) busy_bad = 1;
            @(negedge clk);
        end
        req_valid = 1'b0;
        check("R8 ready low while busy", 48'(busy_bad), 48'd0);
        @(negedge clk);
        check("R8 ready back after rsp", 48'(req_ready), 48'd1);
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin
            l2_mem[i] = 32'h1111 * i + 32'h7;
            shadow[i] = 32'h1111 * i + 32'h7;
        end
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 ready", 48'(req_ready), 48'd1);
        check("R1 idle outputs", {45'd0, |bc_valid, l2_valid, rsp_valid}, 48'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", {44'd0, |bc_valid, l2_valid, rsp_valid, ~req_ready}, 48'd0);

        run_op(0, 0, 32'h3, 32'h0, "R2", 0);
        run_op(1, 3, 32'h3, 32'hCAFE0001, "R3", 0);
        run_op(0, 6, 32'h3, 32'h0, "R2", 0);
        run_op(2, 7, 32'h9, 32'h10, "R4", 0);
        run_op(2, 2, 32'h9, 32'h5, "R4", 1);
        run_op(0, 5, 32'h9, 32'h0, "R2", 0);

        // R6 / R7: straggler on L1 4 while stray acks arrive elsewhere
        hold_mask = 8'h10;
        fork
            run_op(1, 1, 32'hC, 32'h0BAD0BAD, "R3", 0);
            begin
                while (!(bc_valid == 8'h10 && bc_op == 2'd0)) @(negedge clk);
                #1;
                spur_mask = 8'hEF;
                repeat (8) @(negedge clk);
                check("R7 stray acks ignored", mk(2'd0, bc_op, 8'd0, 32'(bc_valid)),
                      mk(2'd0, 2'd0, 8'd0, 32'h10));
                check("R6 step waits for straggler", 48'(l2_valid), 48'd0);
                #1;
                spur_mask = '0;
                hold_mask = '0;
            end
        join
        run_op(0, 4, 32'hC, 32'h0, "R2", 0);
        repeat (5) @(negedge clk);
        check("R8 no leftover expected items", 48'(expq.size()), 48'd0);
        finish_up();
    end

    initial begin
        repeat (100000) @(posedge clk);
        compared++;
        mismatched++;
        $display("FAIL watchdog expired, actual=hung expected=done");
        finish_up();
    end

endmodule